// File: doc/BRIEF.md
# Set/Clear GPIO Bank

A memory-mapped bank of up to 32 general-purpose I/O pins on a plain single-cycle register bus. The bus has an address, write data, a write strobe and read data. Output levels never change through a read-modify-write of a data register. Software raises pin latches through a write-one-to-set address and lowers them through a separate write-one-to-clear address, so two agents can update different pins without a lost update. A direction register decides which pins drive their pads. Two function-select registers hold a 2-bit code per pin, which the pad multiplexers outside the block decode.

`NPINS` sets how many of the 32 bit positions are populated. Bits above it read as zero and ignore writes. `INV_MASK` marks pins whose direction bit and plain-GPIO function code have reversed polarity. On those pins a direction bit of 0 means output, and function code 1 means plain GPIO. Pad input levels arrive already synchronized.

The register bus carries one access per cycle with no back-pressure. Writes take effect at the next rising clock edge. Read data is combinational from the address presented in the same cycle.

Top module: `gpio_bank_sc`

## Requirements
- R1: After reset, pad_oe and pad_out are all zero, and every present pin selects plain GPIO (pin_is_gpio equals the present mask). The direction register reads INV_MASK & present, and each present pin's function field reads 1 if inverted and 0 otherwise.
- R2: A write to address 1 sets each output latch whose write-data bit is 1, visible on pad_out after the next rising edge. Zero bits leave their latches unchanged.
- R3: A write to address 2 clears each output latch whose write-data bit is 1, visible on pad_out after the next rising edge. Zero bits leave their latches unchanged.
- R4: Reads of address 1 and address 2 return zero.
- R5: A read of address 0 returns pad_in masked to the present pins in the same cycle, independent of the output latches.
- R6: Address 3 is the read/write direction register. For each present pin n, pad_oe[n] = dir[n] XOR INV_MASK[n].
- R7: Address 4 holds the function codes of pins 0..15 and address 5 holds those of pins 16..31. Pin n's code sits at bits 2*(n mod 16)+1 : 2*(n mod 16). pin_func carries pin n's code at bits 2n+1:2n. pin_is_gpio[n] is 1 when the code is 0 on a normal pin or 1 on an inverted pin.
- R8: Bits of absent pins (n >= NPINS) read as zero in every register, ignore writes, and keep pad_oe, pad_out, pin_func and pin_is_gpio at zero.
- R9: The output latch can be loaded while the pin is an input and pad_out follows the latch regardless of direction. When the direction write turns the pad on, the loaded level is already present on pad_out.
- R10: Addresses 6 and 7 read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pad_in | input | 32 | Synchronized pad input levels |
| pad_oe | output | 32 | Pad output enable, 1 = drive |
| pad_out | output | 32 | Pad output level (output latch) |
| pin_func | output | 64 | Per-pin 2-bit function code |
| pin_is_gpio | output | 32 | 1 where the pin's code selects plain GPIO |

## Verification
A latch, direction or function bit that holds the wrong value appears on pad_out, pad_oe, pin_func or pin_is_gpio one edge after the write that should have set it. It also appears on read data as soon as the register address is presented. A polarity mistake on an inverted pin shows up at reset, as a driven pad or a non-GPIO function. A leak into an absent pin shows up as a nonzero bit above NPINS. The bench sweeps every pin position and every function code on a 21-pin bank with a mixed inversion mask, so each such fault shows within a few cycles of its sweep.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int BANK_PINS = 32;
  localparam int FN_PINS   = 16;
  localparam int FN_BITS   = 2;
  localparam int ADDR_W    = 3;

  localparam logic [ADDR_W-1:0] A_LEVEL = 3'd0;
  localparam logic [ADDR_W-1:0] A_SET   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CLR   = 3'd2;
  localparam logic [ADDR_W-1:0] A_DIR   = 3'd3;
  localparam logic [ADDR_W-1:0] A_FN_LO = 3'd4;
  localparam logic [ADDR_W-1:0] A_FN_HI = 3'd5;

  // Bit n set for every populated pin below n_present.
  function automatic logic [BANK_PINS-1:0] present_mask(int n_present);
    logic [BANK_PINS-1:0] m;
    m = '0;
    for (int i = 0; i < BANK_PINS; i++) m[i] = (i < n_present);
    return m;
  endfunction

  // Spread a 16-bit pin mask to a 32-bit field mask (2 bits per pin).
  function automatic logic [FN_PINS*FN_BITS-1:0] widen2(logic [FN_PINS-1:0] m);
    logic [FN_PINS*FN_BITS-1:0] w;
    for (int i = 0; i < FN_PINS; i++) w[FN_BITS*i +: FN_BITS] = {FN_BITS{m[i]}};
    return w;
  endfunction
endpackage

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
  parameter int W = 32,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic [W-1:0] set_bits,
  input  logic         clr_we,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (set_we) q <= q | (set_bits & KEEP);
    else if (clr_we) q <= q & ~(clr_bits & KEEP);
  end

  // R2: every present bit written as 1 to the set address is high afterwards
  p_set_hits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((q & $past(set_bits & KEEP)) == $past(set_bits & KEEP)));
  // R3: every present bit written as 1 to the clear address is low afterwards
  p_clr_hits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we) |=> ((q & $past(clr_bits & KEEP)) == '0));
  // R2/R3: zero bits and idle cycles leave the latch alone
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(q));
  p_set_only_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((q & $past(q)) == $past(q)));
endmodule

// File: rtl/gpio_masked_reg.sv
module gpio_masked_reg #(
  parameter int W = 32,
  parameter logic [W-1:0] KEEP = '1,
  parameter logic [W-1:0] RST  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] RST_K = RST & KEEP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST_K;
    else if (we) q <= d & KEEP;
  end

  // R8: bits outside the kept set never hold a one
  p_absent_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (q & ~KEEP) == '0);
  // R6/R7: a register only moves on its own write strobe
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/gpio_func_reg.sv
module gpio_func_reg
  import gpio_bank_pkg::*;
#(
  parameter logic [BANK_PINS-1:0] KEEP = '1,
  parameter logic [BANK_PINS-1:0] INV  = '0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [1:0]                    half_we,
  input  logic [FN_PINS*FN_BITS-1:0]    d,
  output logic [BANK_PINS*FN_BITS-1:0]  fn_q,
  output logic [BANK_PINS-1:0]          is_gpio
);
  localparam int HALVES = BANK_PINS / FN_PINS;
  localparam int HW     = FN_PINS * FN_BITS;
  localparam logic [HW-1:0] LOW_BITS = {FN_PINS{2'b01}};

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    localparam logic [HW-1:0] HKEEP = widen2(KEEP[h*FN_PINS +: FN_PINS]);
    localparam logic [HW-1:0] HRST  = widen2(INV[h*FN_PINS +: FN_PINS]) & LOW_BITS;
    gpio_masked_reg #(.W(HW), .KEEP(HKEEP), .RST(HRST)) u_half (
      .clk(clk), .rst_n(rst_n), .we(half_we[h]), .d(d),
      .q(fn_q[h*HW +: HW]));
  end

  for (genvar p = 0; p < BANK_PINS; p++) begin : g_pin
    localparam logic [FN_BITS-1:0] GPIO_CODE = INV[p] ? 2'd1 : 2'd0;
    assign is_gpio[p] = KEEP[p] && (fn_q[FN_BITS*p +: FN_BITS] == GPIO_CODE);
  end

  // R1/R7: a written half reads back its masked data on the next cycle
  p_lo_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    half_we[0] |=> (fn_q[HW-1:0] == $past(d & widen2(KEEP[FN_PINS-1:0]))));
endmodule

// File: rtl/gpio_bank_sc.sv
module gpio_bank_sc
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32,
  parameter logic [31:0] INV_MASK = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_we,
  output logic [31:0] bus_rdata,
  input  logic [31:0] pad_in,
  output logic [31:0] pad_oe,
  output logic [31:0] pad_out,
  output logic [63:0] pin_func,
  output logic [31:0] pin_is_gpio
);
  localparam logic [BANK_PINS-1:0] PRESENT = present_mask(NPINS);
  localparam logic [BANK_PINS-1:0] INV     = INV_MASK & PRESENT;
  localparam int HW = FN_PINS * FN_BITS;

  logic we_set, we_clr, we_dir;
  logic [1:0] we_fn;
  logic [BANK_PINS-1:0] latch_q, dir_q;

  assign we_set   = bus_we && (bus_addr == A_SET);
  assign we_clr   = bus_we && (bus_addr == A_CLR);
  assign we_dir   = bus_we && (bus_addr == A_DIR);
  assign we_fn[0] = bus_we && (bus_addr == A_FN_LO);
  assign we_fn[1] = bus_we && (bus_addr == A_FN_HI);

  gpio_out_latch #(.W(BANK_PINS), .KEEP(PRESENT)) u_latch (
    .clk(clk), .rst_n(rst_n),
    .set_we(we_set), .set_bits(bus_wdata),
    .clr_we(we_clr), .clr_bits(bus_wdata),
    .q(latch_q));

  // Reset value puts every pin into input mode under its own polarity.
  gpio_masked_reg #(.W(BANK_PINS), .KEEP(PRESENT), .RST(INV)) u_dir (
    .clk(clk), .rst_n(rst_n), .we(we_dir), .d(bus_wdata), .q(dir_q));

  gpio_func_reg #(.KEEP(PRESENT), .INV(INV)) u_func (
    .clk(clk), .rst_n(rst_n), .half_we(we_fn), .d(bus_wdata),
    .fn_q(pin_func), .is_gpio(pin_is_gpio));

  assign pad_out = latch_q;
  assign pad_oe  = (dir_q ^ INV) & PRESENT;

  always_comb begin
    unique case (bus_addr)
      A_LEVEL: bus_rdata = pad_in & PRESENT;
      A_DIR:   bus_rdata = dir_q;
      A_FN_LO: bus_rdata = pin_func[HW-1:0];
      A_FN_HI: bus_rdata = pin_func[2*HW-1:HW];
      default: bus_rdata = '0;
    endcase
  end

  // R4: write-only strobe addresses read as zero
  p_strobe_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_addr == A_SET) || (bus_addr == A_CLR)) |-> (bus_rdata == '0));
  // R10: unmapped addresses read as zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > A_FN_HI) |-> (bus_rdata == '0));
  // R8: absent pins never drive
  p_absent_pads_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | pad_out | pin_is_gpio) & ~PRESENT) == '0);
  // R5: level reads reflect the pads, not the latch
  p_level_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_LEVEL) |-> ((bus_rdata ^ pad_in) & PRESENT) == '0);
  // R9: a direction write leaves the output latch untouched
  p_dir_keeps_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    we_dir |=> $stable(pad_out));
endmodule

// File: tb/tb_gpio_bank_sc.sv
module tb_gpio_bank_sc;
  localparam int NP = 21;
  localparam logic [31:0] INVM = 32'h0214_0009;
  localparam logic [31:0] PRES = (32'd1 << NP) - 32'd1;
  localparam logic [31:0] INVP = INVM & PRES;

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, pad_in = '0, pad_oe, pad_out, pin_is_gpio;
  logic [63:0] pin_func;
  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  logic [31:0] m_lat, m_dir;
  logic [63:0] m_fn;

  always #5 clk = ~clk;

  gpio_bank_sc #(.NPINS(NP), .INV_MASK(INVM)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .pin_func(pin_func), .pin_is_gpio(pin_is_gpio));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] exp_gpio(input logic [63:0] fn);
    logic [31:0] g;
    for (int p = 0; p < 32; p++)
      g[p] = PRES[p] && (fn[2*p +: 2] == (INVM[p] ? 2'd1 : 2'd0));
    return g;
  endfunction

  function automatic logic [31:0] fmask(input int h);
    logic [31:0] m;
    for (int i = 0; i < 16; i++) m[2*i +: 2] = {2{PRES[16*h+i]}};
    return m;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    m_lat = '0; m_dir = INVP; m_fn = '0;
    for (int p = 0; p < 32; p++) if (INVP[p]) m_fn[2*p] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 pad_out", pad_out, 0);
    chk("R1 pin_is_gpio", pin_is_gpio, PRES);
    chk("R1 pin_func", pin_func, m_fn);
    rd(3'd3, r); chk("R1 dir read", r, INVP);
    rd(3'd4, r); chk("R1 fn lo read", r, m_fn[31:0]);
    rd(3'd5, r); chk("R1 fn hi read", r, m_fn[63:32]);

    // R2 / R8 set sweep, one pin at a time, latch accumulates
    for (int p = 0; p < 32; p++) begin
      wr(3'd1, 32'd1 << p);
      m_lat |= (32'd1 << p) & PRES;
      chk("R2 set sweep pad_out", pad_out, m_lat);
    end
    wr(3'd1, 32'h0); chk("R2 zero set no change", pad_out, m_lat);
    // R3 clear sweep
    for (int p = 0; p < 32; p += 2) begin
      wr(3'd2, 32'd1 << p);
      m_lat &= ~(32'd1 << p);
      chk("R3 clear sweep pad_out", pad_out, m_lat);
    end
    wr(3'd2, 32'h0); chk("R3 zero clear no change", pad_out, m_lat);
    wr(3'd2, 32'hFFFF_FFFF); m_lat = '0; chk("R3 clear all", pad_out, 0);
    wr(3'd1, 32'hA5A5_A5A5); m_lat = 32'hA5A5_A5A5 & PRES;
    chk("R8 absent set ignored", pad_out, m_lat);

    // R4 strobe addresses read zero
    rd(3'd1, r); chk("R4 set reads zero", r, 0);
    rd(3'd2, r); chk("R4 clr reads zero", r, 0);

    // R5 level reads pad_in, not latch
    for (int k = 0; k < 6; k++) begin
      pad_in = 32'h1357_9BDF * (k + 1) ^ {16'h0, 16'(k)};
      rd(3'd0, r); chk("R5 level read", r, pad_in & PRES);
    end

    // R6 direction sweep
    for (int p = 0; p < 32; p++) begin
      wr(3'd3, 32'd1 << p);
      m_dir = (32'd1 << p) & PRES;
      chk("R6 pad_oe sweep", pad_oe, (m_dir ^ INVP) & PRES);
      rd(3'd3, r); chk("R6 dir readback", r, m_dir);
    end
    wr(3'd3, 32'hFFFF_FFFF); m_dir = PRES;
    chk("R6 all ones", pad_oe, PRES & ~INVP);
    wr(3'd3, 32'h0); m_dir = 0;
    chk("R6 all zeros", pad_oe, INVP);

    // R7 function code sweep
    for (int p = 0; p < 32; p++) begin
      for (int c = 0; c < 4; c++) begin
        logic [31:0] v;
        int h;
        h = p / 16;
        v = 32'(c) << (2 * (p % 16));
        wr(h ? 3'd5 : 3'd4, v);
        m_fn[32*h +: 32] = v & fmask(h);
        chk("R7 pin_func", pin_func, m_fn);
        chk("R7 pin_is_gpio", pin_is_gpio, exp_gpio(m_fn));
        rd(h ? 3'd5 : 3'd4, r); chk("R7 fn readback", r, m_fn[32*h +: 32]);
      end
    end

    // R9 preload latch as input, then turn on drive
    wr(3'd2, 32'hFFFF_FFFF); m_lat = 0;
    wr(3'd3, INVP); m_dir = INVP;
    chk("R9 inputs", pad_oe, 0);
    wr(3'd1, 32'h0012_3456); m_lat = 32'h0012_3456 & PRES;
    chk("R9 preload while input", pad_out, m_lat);
    chk("R9 still input", pad_oe, 0);
    wr(3'd3, PRES ^ INVP);
    chk("R9 drive on", pad_oe, PRES);
    chk("R9 level ready at drive", pad_out, m_lat);

    // R10 unmapped addresses
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd6, r); chk("R10 addr6 reads zero", r, 0);
    rd(3'd7, r); chk("R10 addr7 reads zero", r, 0);
    chk("R10 latch unchanged", pad_out, m_lat);
    chk("R10 drive unchanged", pad_oe, PRES);
    chk("R10 func unchanged", pin_func, m_fn);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule